// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block derives two streams of single-cycle enable ticks from one system clock. Each stream comes from a divider with an integer part and a fractional part counted in sixteenths of a clock. The fraction is applied by lengthening chosen periods by one extra system clock, so that across sixteen periods the average period equals the programmed value exactly.

The first channel feeds an infrared pulse shaper. It is meant to be programmed so that its tick rate sits close to a 1.8432 MHz reference. The second channel feeds a UART and produces its 16x oversampling tick. A second output marks every sixteenth oversampling tick as the bit boundary.

Software programs both channels through four 16-bit write-only registers on a simple write strobe bus. Any accepted write to a channel restarts that channel from a known phase. A zero integer setting for the infrared channel is refused and is recorded in a sticky flag.

Top module: `fracbaud_gen`

## Requirements
- R1: The infrared integer setting is held in bits [3:0] of the register at offset 0x24 and equals the divisor minus one. With a fraction of zero, `ir_tick` pulses once every (setting + 1) system clocks.
- R2: The fraction index of a channel is held in bits [7:4] of its correction register: offset 0x22 for infrared and 0x3C for UART. The period right after a restart is never lengthened. Each completed period adds the index to a 4-bit accumulator that starts at 0. When that addition carries out of 4 bits, the following period is one system clock longer.
- R3: A write of 0 into bits [3:0] at offset 0x24 is ignored. The stored setting, the tick phase and the tick schedule all stay unchanged, and `cfg_err` goes to 1 in the next cycle and then stays at 1.
- R4: An accepted write to either register of a channel clears that channel's period counter, accumulator and stretch state at the write's clock edge. The first tick then comes (setting + 1) cycles after that edge. The other channel is not disturbed.
- R5: The UART integer setting is held in bits [7:0] of the register at offset 0x3E. `os_tick` is produced with divisor (setting + 1) plus the fraction under the rule of R2, giving a bit period of 16 × (setting + 1) + index clocks.
- R6: `bit_tick` is high together with every sixteenth `os_tick` counted from the last UART restart, and is low at all other times.
- R7: Synchronous active-low reset sets both integer settings to 1 and both fractions to 0, and clears `cfg_err`. During reset all tick outputs are low. After reset both channels tick every 2 cycles.
- R8: A write to any other offset changes nothing in either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one write per cycle |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 16 | Register write data |
| ir_tick | output | 1 | Infrared reference tick |
| os_tick | output | 1 | UART 16x oversampling tick |
| bit_tick | output | 1 | UART bit boundary tick |
| cfg_err | output | 1 | Sticky flag for a refused zero infrared setting |

## Verification
Some properties are checked by assertions on every cycle. The period counter never passes its end value. The stretch bit changes only at a period boundary or a restart. A restart leaves the counter and accumulator at zero. The stored infrared setting is never zero, and a refused write leaves it unchanged while `cfg_err` stays set. A bit tick never appears without an oversampling tick. Other behaviour can only be shown by the bench's scenarios, which compare every tick cycle against a schedule computed independently: where the carries fall for several fraction indices, the exact first-tick delay after a write, each channel's independence from writes to the other, and the count of sixteen oversampling ticks per bit.

// File: rtl/fbg_pkg.sv
// Package: register offsets and field layout shared by the tick generator.
package fbg_pkg;
    localparam int DATA_W     = 16;
    localparam int FRAC_W     = 4;
    localparam int FRAC_LSB   = 4;
    localparam logic [7:0] OFF_IR_FRAC = 8'h22;
    localparam logic [7:0] OFF_IR_CNT  = 8'h24;
    localparam logic [7:0] OFF_UA_FRAC = 8'h3C;
    localparam logic [7:0] OFF_UA_CNT  = 8'h3E;
endpackage

// File: rtl/fbg_frac_div.sv
// Fractional divider: emits one tick per period of (div_m1 + 1) clocks, with
// selected periods stretched by one clock as a FRAC_W-bit accumulator carries.
// Assumes div_m1 and frac change only together with restart.
module fbg_frac_div #(
    parameter int CNT_W  = 4,
    parameter int FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic [CNT_W-1:0]  div_m1,
    input  logic [FRAC_W-1:0] frac,
    output logic              tick
);
    logic [CNT_W:0]  pos;
    logic [CNT_W:0]  last;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   acc_sum;
    logic            ext;

    // End value of the current period, including a pending stretch.
    always_comb begin
        last    = {1'b0, div_m1} + {{CNT_W{1'b0}}, ext};
        acc_sum = {1'b0, acc} + {1'b0, frac};
    end

    assign tick = (pos == last);

    // Period counter, accumulator and stretch flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            pos <= '0;
            acc <= '0;
            ext <= 1'b0;
        end else if (tick) begin
            pos <= '0;
            acc <= acc_sum[FRAC_W-1:0];
            ext <= acc_sum[FRAC_W];
        end else begin
            pos <= pos + 1'b1;
        end
    end

    p_pos_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pos <= last);
    p_restart_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (pos == '0) && (acc == '0) && !ext);
    p_stretch_at_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ext) |-> $past(tick || restart));
endmodule

// File: rtl/fbg_bit_tick.sv
// Bit boundary marker: counts oversampling ticks and flags every OSR-th one.
// Assumes OSR is a power of two of at least 2.
module fbg_bit_tick #(
    parameter int OSR = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic os_tick,
    output logic bit_tick
);
    localparam int OW = $clog2(OSR);
    localparam logic [OW-1:0] OLAST = OW'(OSR - 1);

    logic [OW-1:0] oc;

    assign bit_tick = os_tick && (oc == OLAST);

    // Oversample position within the current bit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            oc <= '0;
        end else if (os_tick) begin
            oc <= (oc == OLAST) ? '0 : oc + 1'b1;
        end
    end

    p_bit_with_os_r6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick);
endmodule

// File: rtl/fbg_regs.sv
// Register decode: holds both channels' settings and raises per-channel
// restart strobes. Refuses a zero infrared setting and records it.
// Assumes UA_CNT_W <= 8 and IR_CNT_W <= FRAC_LSB.
module fbg_regs
    import fbg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int IR_CNT_W = 4,
    parameter int UA_CNT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [IR_CNT_W-1:0] ir_div_m1,
    output logic [FRAC_W-1:0]   ir_frac,
    output logic [UA_CNT_W-1:0] ua_div_m1,
    output logic [FRAC_W-1:0]   ua_frac,
    output logic                ir_restart,
    output logic                ua_restart,
    output logic                cfg_err
);
    logic hit_ir_frac, hit_ir_cnt, hit_ua_frac, hit_ua_cnt, ir_zero;
    logic [FRAC_W-1:0] wfrac;
    logic unused_hi_bits;

    assign unused_hi_bits = ^bus_wdata[DATA_W-1:8];
    assign wfrac = bus_wdata[FRAC_LSB +: FRAC_W];

    // Address decode and restart strobes.
    always_comb begin
        hit_ir_frac = bus_wr && (bus_addr == ADDR_W'(OFF_IR_FRAC));
        hit_ir_cnt  = bus_wr && (bus_addr == ADDR_W'(OFF_IR_CNT));
        hit_ua_frac = bus_wr && (bus_addr == ADDR_W'(OFF_UA_FRAC));
        hit_ua_cnt  = bus_wr && (bus_addr == ADDR_W'(OFF_UA_CNT));
        ir_zero     = hit_ir_cnt && (bus_wdata[IR_CNT_W-1:0] == '0);
        ir_restart  = hit_ir_frac || (hit_ir_cnt && !ir_zero);
        ua_restart  = hit_ua_frac || hit_ua_cnt;
    end

    // Setting storage and sticky error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_div_m1 <= IR_CNT_W'(1);
            ir_frac   <= '0;
            ua_div_m1 <= UA_CNT_W'(1);
            ua_frac   <= '0;
            cfg_err   <= 1'b0;
        end else begin
            if (hit_ir_frac) ir_frac <= wfrac;
            if (hit_ir_cnt && !ir_zero) ir_div_m1 <= bus_wdata[IR_CNT_W-1:0];
            if (hit_ua_frac) ua_frac <= wfrac;
            if (hit_ua_cnt) ua_div_m1 <= bus_wdata[UA_CNT_W-1:0];
            if (ir_zero) cfg_err <= 1'b1;
        end
    end

    p_ir_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_div_m1 != '0);
    p_zero_refused_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ir_zero |=> (ir_div_m1 == $past(ir_div_m1)) && cfg_err);
    p_err_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
endmodule

// File: rtl/fracbaud_gen.sv
// Top: two fractional tick channels (infrared reference, UART oversample)
// plus the UART bit boundary marker, programmed over a 16-bit write bus.
module fracbaud_gen
    import fbg_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int IR_CNT_W = 4,
    parameter int UA_CNT_W = 8,
    parameter int OSR      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ir_tick,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              cfg_err
);
    logic [IR_CNT_W-1:0] ir_div_m1;
    logic [UA_CNT_W-1:0] ua_div_m1;
    logic [FRAC_W-1:0]   ir_frac, ua_frac;
    logic                ir_restart, ua_restart;

    fbg_regs #(.ADDR_W(ADDR_W), .IR_CNT_W(IR_CNT_W), .UA_CNT_W(UA_CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ir_div_m1(ir_div_m1), .ir_frac(ir_frac),
        .ua_div_m1(ua_div_m1), .ua_frac(ua_frac), .ir_restart(ir_restart),
        .ua_restart(ua_restart), .cfg_err(cfg_err)
    );

    fbg_frac_div #(.CNT_W(IR_CNT_W), .FRAC_W(FRAC_W)) i_ir_div (
        .clk(clk), .rst_n(rst_n), .restart(ir_restart), .div_m1(ir_div_m1),
        .frac(ir_frac), .tick(ir_tick)
    );

    fbg_frac_div #(.CNT_W(UA_CNT_W), .FRAC_W(FRAC_W)) i_ua_div (
        .clk(clk), .rst_n(rst_n), .restart(ua_restart), .div_m1(ua_div_m1),
        .frac(ua_frac), .tick(os_tick)
    );

    fbg_bit_tick #(.OSR(OSR)) i_bit (
        .clk(clk), .rst_n(rst_n), .restart(ua_restart), .os_tick(os_tick),
        .bit_tick(bit_tick)
    );
endmodule

// File: tb/test_fracbaud_gen.sv
`timescale 1ns/1ps
module test_fracbaud_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [15:0] bus_wdata = 16'h0000;
    logic        ir_tick, os_tick, bit_tick, cfg_err;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int ir_q[$];
    int os_q[$];
    int bt_q[$];
    string ir_tag = "R1";
    string ua_tag = "R5";

    fracbaud_gen i_fracbaud_gen (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ir_tick(ir_tick), .os_tick(os_tick),
        .bit_tick(bit_tick), .cfg_err(cfg_err)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops expected tick cycles and compares against observed ticks.
    always @(negedge clk) begin
        if (ir_q.size() > 0) begin
            if (ir_tick) begin
                chk(ir_q[0] == cyc, ir_tag, "ir_tick cycle", cyc, ir_q[0]);
                void'(ir_q.pop_front());
            end else if (ir_q[0] == cyc) begin
                chk(1'b0, ir_tag, "ir_tick missing at cycle", 0, cyc);
                void'(ir_q.pop_front());
            end
        end
        if (os_q.size() > 0) begin
            if (os_tick) begin
                chk(os_q[0] == cyc, ua_tag, "os_tick cycle", cyc, os_q[0]);
                void'(os_q.pop_front());
            end else if (os_q[0] == cyc) begin
                chk(1'b0, ua_tag, "os_tick missing at cycle", 0, cyc);
                void'(os_q.pop_front());
            end
        end
        if (bt_q.size() > 0) begin
            if (bit_tick) begin
                chk(bt_q[0] == cyc, "R6", "bit_tick cycle", cyc, bt_q[0]);
                void'(bt_q.pop_front());
            end else if (bt_q[0] == cyc) begin
                chk(1'b0, "R6", "bit_tick missing at cycle", 0, cyc);
                void'(bt_q.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [15:0] d, output int w);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_wr = 1'b0;
        w = cyc;
    endtask

    // Driver: program a channel and push its expected tick schedule.
    task automatic push_sched(input int w, input int div, input int idx, input int n,
                              input bit uart);
        int t = w - 1;
        int acc = 0;
        int ext = 0;
        for (int i = 1; i <= n; i++) begin
            int s;
            t += div + ext;
            if (uart) begin
                os_q.push_back(t);
                if (i % 16 == 0) bt_q.push_back(t);
            end else begin
                ir_q.push_back(t);
            end
            s = acc + idx;
            ext = (s >= 16) ? 1 : 0;
            acc = s % 16;
        end
    endtask

    task automatic cfg_ir(input int cnt, input int idx, input int n);
        int w;
        ir_q.delete();
        bus_write(8'h22, 16'(idx << 4), w);
        bus_write(8'h24, 16'(cnt), w);
        push_sched(w, cnt + 1, idx, n, 1'b0);
    endtask

    task automatic cfg_uart(input int cnt, input int idx, input int n);
        int w;
        os_q.delete();
        bt_q.delete();
        bus_write(8'h3C, 16'(idx << 4), w);
        bus_write(8'h3E, 16'(cnt), w);
        push_sched(w, cnt + 1, idx, n, 1'b1);
    endtask

    task automatic drain();
        wait (ir_q.size() == 0 && os_q.size() == 0 && bt_q.size() == 0);
        repeat (4) @(posedge clk);
    endtask

    initial begin
        int w;
        int n_ir;
        int n_os;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!ir_tick && !os_tick && !bit_tick, "R7", "ticks low in reset",
            {ir_tick, os_tick, bit_tick}, 0);
        chk(cfg_err == 1'b0, "R7", "cfg_err after reset", cfg_err, 0);
        rst_n = 1'b1;
        n_ir = 0; n_os = 0;
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            if (ir_tick) n_ir++;
            if (os_tick) n_os++;
        end
        chk(n_ir == 16, "R7", "ir ticks in 32 cycles at reset setting", n_ir, 16);
        chk(n_os == 16, "R7", "os ticks in 32 cycles at reset setting", n_os, 16);

        ir_tag = "R1/R4";
        cfg_ir(5, 0, 8);
        drain();
        ir_tag = "R2";
        cfg_ir(3, 5, 20);
        drain();
        cfg_ir(15, 15, 20);
        drain();
        cfg_ir(1, 1, 20);
        drain();

        // Zero setting, stray address and other-channel writes during an IR run.
        ir_tag = "R3/R4/R8";
        cfg_ir(2, 7, 30);
        repeat (10) @(posedge clk);
        chk(cfg_err == 1'b0, "R3", "cfg_err before zero write", cfg_err, 0);
        bus_write(8'h24, 16'h0010, w);
        @(negedge clk);
        chk(cfg_err == 1'b1, "R3", "cfg_err after zero write", cfg_err, 1);
        bus_write(8'h26, 16'h0000, w);
        bus_write(8'h20, 16'h00F3, w);
        bus_write(8'h3E, 16'h0004, w);
        bus_write(8'h3C, 16'h00A0, w);
        drain();

        ua_tag = "R5";
        cfg_uart(0, 8, 40);
        drain();
        ua_tag = "R5/R2";
        cfg_uart(2, 3, 48);
        drain();
        ua_tag = "R5/R4";
        cfg_uart(6, 13, 33);
        drain();

        chk(cfg_err == 1'b1, "R3", "cfg_err stays set", cfg_err, 1);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete actual=%0d expected=%0d", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule